// File: doc/BRIEF.md
# Soft-Output Viterbi Decoder (4-state, rate 1/2)

This block decodes a rate-1/2 convolutional code whose encoder holds two past input bits, so the trellis has four states. Every clock on which `in_valid` is high it takes one pair of signed soft channel samples. A fixed number of accepted symbols later it emits the decided data bit together with an unsigned 7-bit confidence value.

The datapath is a cascade. Branch-metric logic scores each of the four possible code pairs. A state-metric recursion keeps unsigned path metrics and renormalises them every step. A register-exchange survivor memory carries the hard decisions of every state's survivor. Alongside it runs a second register-exchange plane that carries one reliability value per stored bit. When two paths merge, an XOR per stored position compares the winner's bit with the loser's bit. Only at positions where they disagree is the reliability lowered to the metric difference of the merge, and only inside a window of the newest positions. The older positions then give the path time to converge before the bit is released.

The decided bit and its reliability are taken from the oldest position of the state that has the smallest metric.

Top module: `sova_decoder`

## Requirements
- R1: Code and sign convention. The state is {u[k-1], u[k-2]}. The first coded bit of a step is u^u[k-1]^u[k-2] and the second is u^u[k-2], carried in `in_soft0` and `in_soft1`. A positive sample stands for a coded 1. The full-scale values are +7 for a 1 and -8 for a 0. The encoder starts in state 0.
- R2: For noise-free full-scale input, every output bit equals the encoder input bit of the same index, for any data pattern.
- R3: The output for symbol k is registered on the clock edge that accepts symbol k+24. `out_valid` is high only in the cycle after an accepted symbol that had at least 24 accepted symbols before it since reset.
- R4: A cycle with `in_valid` low changes no decoder state. Idle cycles inserted between symbols leave the bit and reliability sequence unchanged.
- R5: Reliability is the smallest metric difference among competing paths that disagree with the decision at that bit and merge while the bit is within the 8 newest positions. A fresh bit starts at 127. With noise-free full-scale input, every bit from index 2 on reports 75.
- R6: When one sample of symbol k is sign-inverted at full scale, all bits are still decided correctly and bit k reports a reliability of at most 45.
- R7: A competitor that agrees at a bit does not lower that bit's reliability. In the R6 stimulus, bit k-5 still reports 75.
- R8: While and just after synchronous reset, `out_valid`, `out_bit` and `out_rel` are 0.
- R9: Path metrics are renormalised each step so that the smallest is 0. Decoding stays correct over streams of several hundred symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A soft sample pair is presented this cycle |
| in_soft0 | input | 4 | Signed soft sample of the first coded bit |
| in_soft1 | input | 4 | Signed soft sample of the second coded bit |
| out_valid | output | 1 | Decided bit and reliability are valid |
| out_bit | output | 1 | Hard decision |
| out_rel | output | 7 | Unsigned reliability of the decision |

## Verification
A wrong selection or a bad metric shows up as wrong output bits exactly 24 accepted symbols after the step that went wrong. A corrupted reliability plane only shows in `out_rel`, which is why clean streams are checked for the exact value 75. A missing XOR gate makes correct neighbours of a single corrupted symbol report a lowered value. That would show at bit k-5 roughly 19 symbols after the corrupted one is fed. Idle cycles that disturb state would corrupt the following outputs within one latency window.

// File: rtl/sova_pkg.sv
package sova_pkg;
  localparam int NSTATE = 4;

  // coded pair {first, second} for input u leaving state s = {u[k-1], u[k-2]}
  function automatic logic [1:0] code_pair(input logic u, input logic [1:0] s);
    return {u ^ s[1] ^ s[0], u ^ s[0]};
  endfunction
endpackage

// File: rtl/sova_bmu.sv
module sova_bmu #(
  parameter int SW  = 4,
  parameter int BMW = SW + 1
) (
  input  logic signed [SW-1:0]    y0,
  input  logic signed [SW-1:0]    y1,
  output logic [3:0][BMW-1:0]     bm
);
  logic [SW-1:0] off0, off1;

  // offset binary: 0 = strongest "zero", all ones = strongest "one"
  assign off0 = {~y0[SW-1], y0[SW-2:0]};
  assign off1 = {~y1[SW-1], y1[SW-2:0]};

  for (genvar c = 0; c < 4; c++) begin : g_pair
    logic [SW-1:0] cost0, cost1;
    assign cost0 = (c / 2 == 1) ? ~off0 : off0;
    assign cost1 = (c % 2 == 1) ? ~off1 : off1;
    assign bm[c] = BMW'(cost0) + BMW'(cost1);
  end
endmodule

// File: rtl/sova_acs.sv
module sova_acs
  import sova_pkg::*;
#(
  parameter int MW        = 7,
  parameter int BMW       = 5,
  parameter int INIT_BIAS = 96
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [3:0][BMW-1:0]       bm,
  output logic [3:0][MW-1:0]        pm,
  output logic [3:0]                dec,
  output logic [3:0][MW-1:0]        delta
);
  localparam logic [MW:0] MAXM = {1'b0, {MW{1'b1}}};

  logic [3:0][MW-1:0] pm_q;
  logic [3:0][MW-1:0] sel;
  logic [MW-1:0]      floor_v;

  for (genvar ns = 0; ns < NSTATE; ns++) begin : g_state
    localparam int          PA = (ns % 2) * 2;
    localparam int          PB = PA + 1;
    localparam logic        U  = (ns / 2) == 1;
    localparam logic [1:0]  CA = code_pair(U, 2'(PA));
    localparam logic [1:0]  CB = code_pair(U, 2'(PB));
    logic [MW:0]   sum_a, sum_b;
    logic [MW-1:0] cand_a, cand_b;

    always_comb begin
      sum_a  = {1'b0, pm_q[PA]} + (MW+1)'(bm[CA]);
      sum_b  = {1'b0, pm_q[PB]} + (MW+1)'(bm[CB]);
      cand_a = (sum_a > MAXM) ? MAXM[MW-1:0] : sum_a[MW-1:0];
      cand_b = (sum_b > MAXM) ? MAXM[MW-1:0] : sum_b[MW-1:0];
      dec[ns]   = cand_b < cand_a;
      sel[ns]   = dec[ns] ? cand_b : cand_a;
      delta[ns] = dec[ns] ? (cand_a - cand_b) : (cand_b - cand_a);
    end
  end

  always_comb begin
    floor_v = sel[0];
    for (int s = 1; s < NSTATE; s++)
      if (sel[s] < floor_v) floor_v = sel[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSTATE; s++)
        pm_q[s] <= (s == 0) ? '0 : MW'(INIT_BIAS);
    end else if (en) begin
      for (int s = 0; s < NSTATE; s++)
        pm_q[s] <= sel[s] - floor_v;
    end
  end

  assign pm = pm_q;

  // R9: after every step at least one state metric sits at zero
  a_r9_norm_floor: assert property (@(posedge clk) disable iff (rst)
    (pm_q[0] == '0) || (pm_q[1] == '0) || (pm_q[2] == '0) || (pm_q[3] == '0));

  // R4: metrics frozen on idle cycles
  a_r4_metric_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pm_q));
endmodule

// File: rtl/sova_rex.sv
module sova_rex
  import sova_pkg::*;
#(
  parameter int LAT       = 24,
  parameter int REL_DEPTH = 8,
  parameter int RW        = 7
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic [3:0]                       dec,
  input  logic [3:0][RW-1:0]               delta,
  output logic [3:0][LAT-1:0]              paths,
  output logic [3:0][LAT-1:0][RW-1:0]      rels
);
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};

  logic [3:0][LAT-1:0]          p_q, p_d;
  logic [3:0][LAT-1:0][RW-1:0]  r_q, r_d;

  for (genvar s = 0; s < NSTATE; s++) begin : g_state
    logic [1:0] win, lose;
    assign win  = {1'(s % 2), dec[s]};
    assign lose = {1'(s % 2), ~dec[s]};

    // newest position: the input bit that leads into state s
    assign p_d[s][0] = 1'((s / 2) == 1);
    assign r_d[s][0] = RMAX;

    for (genvar j = 1; j < LAT; j++) begin : g_pos
      logic differ;
      assign differ     = p_q[win][j-1] ^ p_q[lose][j-1];
      assign p_d[s][j]  = p_q[win][j-1];
      if (j <= REL_DEPTH) begin : g_upd
        assign r_d[s][j] = (differ && (delta[s] < r_q[win][j-1])) ? delta[s] : r_q[win][j-1];
      end else begin : g_carry
        assign r_d[s][j] = r_q[win][j-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= '0;
      for (int s = 0; s < NSTATE; s++)
        for (int j = 0; j < LAT; j++)
          r_q[s][j] <= RMAX;
    end else if (en) begin
      p_q <= p_d;
      r_q <= r_d;
    end
  end

  assign paths = p_q;
  assign rels  = r_q;

  // R4: survivor and reliability planes frozen on idle cycles
  a_r4_path_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(p_q) && $stable(r_q)));

  // R5: a stored reliability never rises as a bit moves to an older position
  a_r5_rel_nonrising: assert property (@(posedge clk) disable iff (rst)
    en |=> (r_q[0][1] <= RMAX) && (r_q[0][LAT-1] <= $past(r_q[{1'b0, dec[0]}][LAT-2])));
endmodule

// File: rtl/sova_decoder.sv
module sova_decoder
  import sova_pkg::*;
#(
  parameter int SW        = 4,
  parameter int MW        = 7,
  parameter int VIT_DEPTH = 16,
  parameter int REL_DEPTH = 8,
  parameter int INIT_BIAS = 96
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_soft0,
  input  logic signed [SW-1:0] in_soft1,
  output logic                 out_valid,
  output logic                 out_bit,
  output logic [MW-1:0]        out_rel
);
  localparam int LAT = VIT_DEPTH + REL_DEPTH;
  localparam int BMW = SW + 1;
  localparam int FW  = $clog2(LAT + 1);

  logic [3:0][BMW-1:0]        bm;
  logic [3:0][MW-1:0]         pm;
  logic [3:0]                 dec;
  logic [3:0][MW-1:0]         delta;
  logic [3:0][LAT-1:0]        paths;
  logic [3:0][LAT-1:0][MW-1:0] rels;
  logic [1:0]                 best;
  logic [FW-1:0]              fill;

  sova_bmu #(.SW(SW), .BMW(BMW)) u_bmu (
    .y0(in_soft0), .y1(in_soft1), .bm(bm));

  sova_acs #(.MW(MW), .BMW(BMW), .INIT_BIAS(INIT_BIAS)) u_acs (
    .clk(clk), .rst(rst), .en(in_valid), .bm(bm),
    .pm(pm), .dec(dec), .delta(delta));

  sova_rex #(.LAT(LAT), .REL_DEPTH(REL_DEPTH), .RW(MW)) u_rex (
    .clk(clk), .rst(rst), .en(in_valid), .dec(dec), .delta(delta),
    .paths(paths), .rels(rels));

  always_comb begin
    best = 2'd0;
    for (int s = 1; s < NSTATE; s++)
      if (pm[s] < pm[best]) best = 2'(s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_rel   <= '0;
    end else begin
      out_valid <= in_valid && (fill == FW'(LAT));
      if (in_valid) begin
        if (fill != FW'(LAT)) fill <= fill + 1'b1;
        out_bit <= paths[best][LAT-1];
        out_rel <= rels[best][LAT-1];
      end
    end
  end

  // R3: an output only follows an accepted symbol
  a_r3_out_follows_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R3: an idle cycle produces no output in the next cycle
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

// File: tb/tb_sova_decoder.sv
module tb_sova_decoder;
  localparam int LAT  = 24;
  localparam int MAXN = 400;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [3:0] in_soft0 = '0;
  logic signed [3:0] in_soft1 = '0;
  logic              out_valid;
  logic              out_bit;
  logic [6:0]        out_rel;

  int n_checks = 0;
  int n_fail   = 0;

  logic       data [MAXN];
  logic       got_bit [MAXN + LAT];
  logic [6:0] got_rel [MAXN + LAT];
  int         n_out;
  int         acc_cnt;
  int         first_out_acc;

  always #5 clk = ~clk;

  sova_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_soft0(in_soft0), .in_soft1(in_soft1),
    .out_valid(out_valid), .out_bit(out_bit), .out_rel(out_rel));

  always @(posedge clk) begin
    if (rst) acc_cnt <= 0;
    else if (in_valid) acc_cnt <= acc_cnt + 1;
  end

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (n_out == 0) first_out_acc = acc_cnt;
      if (n_out < MAXN + LAT) begin
        got_bit[n_out] = out_bit;
        got_rel[n_out] = out_rel;
      end
      n_out++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_le(input string req, input string what, input int act, input int lim);
    n_checks++;
    if (act > lim) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected <= %0d", req, what, act, lim);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_out = 0;
    first_out_acc = -1;
  endtask

  function automatic logic [3:0] full(input logic b);
    return b ? 4'sd7 : -4'sd8;
  endfunction

  // pattern: 0 zeros, 1 ones, 2 alternating, 3 LFSR
  task automatic make_data(input int n, input int pat);
    logic [7:0] lf = 8'hA5;
    for (int i = 0; i < n; i++) begin
      case (pat)
        0: data[i] = 1'b0;
        1: data[i] = 1'b1;
        2: data[i] = 1'(i % 2);
        default: begin
          data[i] = lf[0];
          lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[4], lf[7:1]};
        end
      endcase
    end
  endtask

  // drives n data symbols plus LAT zero tail; gap inserts idle cycles, flip inverts sample 0 of that symbol
  task automatic feed(input int n, input bit gap, input int flip);
    logic [1:0] st = 2'b00;
    for (int i = 0; i < n + LAT; i++) begin
      logic u, c0, c1;
      u  = (i < n) ? data[i] : 1'b0;
      c0 = u ^ st[1] ^ st[0];
      c1 = u ^ st[0];
      st = {u, st[1]};
      @(negedge clk);
      in_valid = 1'b1;
      in_soft0 = full((i == flip) ? ~c0 : c0);
      in_soft1 = full(c1);
      if (gap && (i % 3 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_soft0 = 4'sd3;
        in_soft1 = -4'sd5;
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_clean(input string tag, input int n);
    int bad_bits = 0, bad_rel = 0;
    check("R3", {tag, " output count"}, n_out, n + LAT - LAT);
    for (int i = 0; i < n; i++) begin
      if (got_bit[i] !== data[i]) bad_bits++;
      if (i >= 2 && got_rel[i] != 7'd75) bad_rel++;
    end
    check("R2", {tag, " wrong bits"}, bad_bits, 0);
    check("R5", {tag, " bits with reliability other than 75"}, bad_rel, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", "out_valid in reset", int'(out_valid), 0);
    check("R8", "out_bit in reset", int'(out_bit), 0);
    check("R8", "out_rel in reset", int'(out_rel), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8", "out_valid after reset", int'(out_valid), 0);
    check("R8", "out_rel after reset", int'(out_rel), 0);
  endtask

  task automatic t_patterns();
    for (int p = 0; p < 4; p++) begin
      do_reset();
      make_data(48, p);
      feed(48, 1'b0, -1);
      check_clean($sformatf("R1 pattern %0d", p), 48);
      check("R3", $sformatf("pattern %0d symbols accepted at first output", p), first_out_acc, LAT + 1);
    end
  endtask

  task automatic t_gaps();
    do_reset();
    make_data(60, 3);
    feed(60, 1'b1, -1);
    check_clean("R4 with idle cycles", 60);
  endtask

  task automatic t_flip();
    do_reset();
    make_data(60, 3);
    feed(60, 1'b0, 30);
    begin
      int bad = 0;
      for (int i = 0; i < 60; i++) if (got_bit[i] !== data[i]) bad++;
      check("R6", "wrong bits with one inverted sample", bad, 0);
    end
    check_le("R6", "reliability of corrupted bit", int'(got_rel[30]), 45);
    check("R7", "reliability five bits before corruption", int'(got_rel[25]), 75);
  endtask

  task automatic t_long();
    do_reset();
    make_data(MAXN, 3);
    feed(MAXN, 1'b0, -1);
    check_clean("R9 long stream", MAXN);
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_out = 0;
    first_out_acc = -1;
    repeat (3) @(negedge clk);
    t_reset();
    t_patterns();
    t_gaps();
    t_flip();
    t_long();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule